// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns a stream of stereo sample pairs into a serial audio link made of a bit clock, a frame (word-select or sync) clock and one data line. It does not make its own bit rate. An outside divider gives one `edge_tick` pulse for every half period of the bit clock. The block toggles its bit clock on each pulse and sends a new data bit and frame level on every falling edge, judged at normal polarity.

Five alignments can be chosen while the link runs: the classic stereo format with a one-bit delay, left-justified, right-justified, and two short-sync formats (sync on the first bit, or data starting one bit after the sync). Either clock can be inverted. The sample width is picked from four sizes. A channel slot is a fixed number of bit periods. Bits outside the sample are sent as zero. A one-entry holding slot takes sample pairs through a valid/ready handshake. The slot and all format controls are sampled only at a frame boundary. If no pair is waiting at that point, the last pair is sent again and an underrun pulse is raised.

Top module: `audio_serial_tx`

## Requirements
- R1: After a synchronous active-low reset, `bclk_o`, `frame_o`, `sdata_o` and `underrun_o` are 0 and `smp_ready` is 1.
- R2: Each `edge_tick` toggles the internal bit clock, which starts low. Every toggle from high to low sends the next bit position. `bclk_o` is the internal level XOR the latched `bclk_inv`, so at normal polarity data is stable at each rising edge of `bclk_o`.
- R3: A frame is 2*SLOT_BITS bit positions long, numbered from 0. Position 0 is the first bit sent after reset. In codes 0, 1 and 2 the normal-polarity frame level is 0 for positions below SLOT_BITS (left) and 1 for the rest (right).
- R4: fmt_sel=0 (delayed stereo): the MSB of each channel goes out at offset 1 of its half. When the width equals the slot, the LSB lands at offset 0 of the following half, even across a frame boundary.
- R5: fmt_sel=1 (left-justified): the MSB of each channel goes out at offset 0 of its half.
- R6: fmt_sel=2 (right-justified): the LSB of each channel goes out at the last offset (SLOT_BITS-1) of its half.
- R7: fmt_sel=4 (sync on first bit): the frame line is high only at position 0. The left MSB goes out at position 0 and the right MSB directly after the left LSB.
- R8: fmt_sel=3 (sync then data): the frame line is the same as in R7, and the data is the R7 stream delayed by one bit position. The last bit can spill into position 0 of the next frame.
- R9: width_sel 0/1/2/3 selects 16/20/24/32 bits, limited to SLOT_BITS and SAMPLE_W. Samples are LSB-aligned and bits above the width are ignored. Every position that carries no sample bit is 0.
- R10: `frame_inv`=1 inverts `frame_o` in every format.
- R11: `smp_ready` is 1 exactly when the holding slot is empty. A handshake fills it, and the slot empties when the next frame starts.
- R12: If the holding slot is empty at a frame start, the previous pair is sent again and `underrun_o` is high for one clock.
- R13: Format, width and both inversions are latched at a frame start and hold for the whole frame. fmt_sel codes 5 to 7 behave as left-justified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_tick | input | 1 | One pulse per bit-clock half period |
| fmt_sel | input | 3 | Alignment code (0 delayed stereo, 1 left, 2 right, 3 sync-then-data, 4 sync-on-first) |
| width_sel | input | 2 | Sample width code (16/20/24/32) |
| bclk_inv | input | 1 | Invert bit clock output |
| frame_inv | input | 1 | Invert frame output |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding slot empty |
| smp_left | input | SAMPLE_W | Left sample, LSB-aligned |
| smp_right | input | SAMPLE_W | Right sample, LSB-aligned |
| bclk_o | output | 1 | Serial bit clock |
| frame_o | output | 1 | Frame / word-select clock |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-clock pulse when a pair is repeated |

## Verification
A wrong bit position counter moves the frame edge and every data bit from then on. It shows on `frame_o` within one bit period and never corrects itself. A stale or wrongly chosen pair, or a format latched mid-frame, changes the serial bits in the very frame it affects, because every bit of every frame is compared against an independently built stream. A faulty one-bit delay flop shows in the delayed formats at the MSB and at position 0 of the frame that follows. A holding slot that is lost or kept too long shows as a wrong `smp_ready` level one clock after the handshake, or as a spurious or missing `underrun_o` pulse at the next frame start.

// File: rtl/audtx_pkg.sv
// Shared types and helpers for the audio serial transmitter.
// Assumes fmt codes are fixed by the block's port definition.
package audtx_pkg;

    typedef enum logic [2:0] {
        FMT_I2S   = 3'd0,
        FMT_LEFT  = 3'd1,
        FMT_RIGHT = 3'd2,
        FMT_DSP_A = 3'd3,
        FMT_DSP_B = 3'd4
    } fmt_e;

    typedef struct packed {
        logic [2:0] fmt;
        logic [1:0] wsel;
        logic       bclk_inv;
        logic       frame_inv;
    } cfg_t;

    // Decode the width code into a bit count.
    function automatic int width_of(input logic [1:0] wsel);
        case (wsel)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/audtx_bit_timer.sv
// Bit timer: turns half-period ticks into a bit clock level, a launch
// strobe on each falling toggle, and the bit position within the frame.
// Assumes edge_tick is a single-cycle pulse from an outside divider.
module audtx_bit_timer #(
    parameter int FRAME_BITS = 64,
    parameter int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_tick,
    output logic             phase_q,
    output logic             launch,
    output logic [POS_W-1:0] pos_next,
    output logic             frame_start
);

    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

    logic [POS_W-1:0] pos_q;

    // Internal bit clock level toggles on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_q <= 1'b0;
        else if (edge_tick) phase_q <= !phase_q;
    end

    // A high-to-low toggle sends the next bit.
    assign launch      = edge_tick && phase_q;
    assign pos_next    = (pos_q == LAST) ? '0 : pos_q + 1'b1;
    assign frame_start = launch && (pos_next == '0);

    // Position of the bit currently on the line; starts at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)      pos_q <= LAST;
        else if (launch) pos_q <= pos_next;
    end

    p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_tick |=> $stable(phase_q));

    p_pos_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && pos_q == LAST) |=> (pos_q == '0));

endmodule

// File: rtl/audtx_sample_hold.sv
// Sample hold: one-entry holding slot behind a valid/ready handshake,
// the active pair and the active configuration, both swapped at frame start.
// Assumes frame_start is a single-cycle strobe.
module audtx_sample_hold
    import audtx_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  cfg_t                cfg_in,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                smp_ready,
    output cfg_t                cfg_eff,
    output logic [SAMPLE_W-1:0] left_eff,
    output logic [SAMPLE_W-1:0] right_eff,
    output logic                bclk_inv_q,
    output logic                underrun_o
);

    logic                pend_q;
    logic [SAMPLE_W-1:0] pend_l, pend_r, act_l, act_r;
    cfg_t                cfg_q;
    logic                take;

    assign smp_ready = !pend_q;
    assign take      = smp_valid && !pend_q;

    // Holding slot: filled by a handshake, emptied at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            pend_l <= '0;
            pend_r <= '0;
        end else if (take) begin
            pend_q <= 1'b1;
            pend_l <= smp_left;
            pend_r <= smp_right;
        end else if (frame_start) begin
            pend_q <= 1'b0;
        end
    end

    // Active pair: replaced at frame start only when a new pair is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_l <= '0;
            act_r <= '0;
        end else if (frame_start && pend_q) begin
            act_l <= pend_l;
            act_r <= pend_r;
        end
    end

    // Configuration latched once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           cfg_q <= '0;
        else if (frame_start) cfg_q <= cfg_in;
    end

    // Underrun pulse when a frame starts with nothing waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) underrun_o <= 1'b0;
        else        underrun_o <= frame_start && !pend_q;
    end

    // Values in force for the bit being launched this cycle.
    assign cfg_eff    = frame_start ? cfg_in : cfg_q;
    assign left_eff   = (frame_start && pend_q) ? pend_l : act_l;
    assign right_eff  = (frame_start && pend_q) ? pend_r : act_r;
    assign bclk_inv_q = cfg_q.bclk_inv;

    p_ready_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);

    p_underrun_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> !underrun_o);

    p_pair_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(act_l) && $stable(act_r)));

    p_cfg_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(cfg_q));

endmodule

// File: rtl/audtx_serializer.sv
// Serializer: picks the sample bit (or zero) for the bit position being
// launched, applies the one-bit delay of the delayed formats and the
// frame polarity, and registers the line outputs.
// Assumes pos_next, the pair and the format are valid whenever launch is high.
module audtx_serializer
    import audtx_pkg::*;
#(
    parameter int SAMPLE_W  = 32,
    parameter int SLOT_BITS = 32,
    parameter int POS_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [POS_W-1:0]    pos_next,
    input  logic [2:0]          fmt,
    input  logic [1:0]          wsel,
    input  logic                frame_inv,
    input  logic [SAMPLE_W-1:0] left,
    input  logic [SAMPLE_W-1:0] right,
    output logic                sd_q,
    output logic                fr_q
);

    int                  p, o, w;
    logic                half, raw_bit, raw_frm, use_delay, dly_q;
    logic [SAMPLE_W-1:0] word, shifted;

    // Bit and frame level for the position being launched.
    always_comb begin
        w = width_of(wsel);
        if (w > SLOT_BITS) w = SLOT_BITS;
        if (w > SAMPLE_W)  w = SAMPLE_W;
        p         = int'(pos_next);
        half      = (p >= SLOT_BITS);
        o         = half ? p - SLOT_BITS : p;
        word      = half ? right : left;
        shifted   = '0;
        raw_frm   = half;
        use_delay = 1'b0;
        case (fmt)
            FMT_RIGHT: begin
                if (o >= SLOT_BITS - w) shifted = word >> (SLOT_BITS - 1 - o);
            end
            FMT_DSP_A, FMT_DSP_B: begin
                raw_frm   = (p == 0);
                use_delay = (fmt == FMT_DSP_A);
                if (p < w)          shifted = left >> (w - 1 - p);
                else if (p < 2 * w) shifted = right >> (2 * w - 1 - p);
            end
            default: begin
                use_delay = (fmt == FMT_I2S);
                if (o < w) shifted = word >> (w - 1 - o);
            end
        endcase
        raw_bit = shifted[0];
    end

    // One-bit delay line, fed on every launch whatever the format.
    always_ff @(posedge clk) begin
        if (!rst_n)      dly_q <= 1'b0;
        else if (launch) dly_q <= raw_bit;
    end

    // Registered line outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q <= 1'b0;
            fr_q <= 1'b0;
        end else if (launch) begin
            sd_q <= use_delay ? dly_q : raw_bit;
            fr_q <= raw_frm ^ frame_inv;
        end
    end

    p_sd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> ($stable(sd_q) && $stable(fr_q)));

    p_sync_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && fmt == FMT_DSP_B && pos_next != '0) |=> (fr_q == $past(frame_inv)));

endmodule

// File: rtl/audio_serial_tx.sv
// Top: multi-format audio serial transmitter. Wires the bit timer, the
// sample hold and the serializer, and applies bit clock polarity.
// Assumes an outside divider supplies edge_tick.
module audio_serial_tx
    import audtx_pkg::*;
#(
    parameter int SAMPLE_W  = 32,
    parameter int SLOT_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                edge_tick,
    input  logic [2:0]          fmt_sel,
    input  logic [1:0]          width_sel,
    input  logic                bclk_inv,
    input  logic                frame_inv,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                bclk_o,
    output logic                frame_o,
    output logic                sdata_o,
    output logic                underrun_o
);

    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);

    logic                phase_q, launch, frame_start, bclk_inv_q;
    logic [POS_W-1:0]    pos_next;
    cfg_t                cfg_in, cfg_eff;
    logic [SAMPLE_W-1:0] left_eff, right_eff;

    assign cfg_in = '{fmt: fmt_sel, wsel: width_sel, bclk_inv: bclk_inv, frame_inv: frame_inv};

    audtx_bit_timer #(
        .FRAME_BITS (FRAME_BITS),
        .POS_W      (POS_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_tick   (edge_tick),
        .phase_q     (phase_q),
        .launch      (launch),
        .pos_next    (pos_next),
        .frame_start (frame_start)
    );

    audtx_sample_hold #(
        .SAMPLE_W (SAMPLE_W)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cfg_in      (cfg_in),
        .smp_valid   (smp_valid),
        .smp_left    (smp_left),
        .smp_right   (smp_right),
        .smp_ready   (smp_ready),
        .cfg_eff     (cfg_eff),
        .left_eff    (left_eff),
        .right_eff   (right_eff),
        .bclk_inv_q  (bclk_inv_q),
        .underrun_o  (underrun_o)
    );

    audtx_serializer #(
        .SAMPLE_W  (SAMPLE_W),
        .SLOT_BITS (SLOT_BITS),
        .POS_W     (POS_W)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .pos_next  (pos_next),
        .fmt       (cfg_eff.fmt),
        .wsel      (cfg_eff.wsel),
        .frame_inv (cfg_eff.frame_inv),
        .left      (left_eff),
        .right     (right_eff),
        .sd_q      (sdata_o),
        .fr_q      (frame_o)
    );

    // Bit clock polarity applied to the registered internal level.
    assign bclk_o = phase_q ^ bclk_inv_q;

endmodule

// File: tb/audio_serial_tx_bench.sv
`timescale 1ns/1ps
module audio_serial_tx_bench;

    localparam int SW   = 32;
    localparam int SLOT = 32;
    localparam int FB   = 2 * SLOT;
    localparam int NF   = 13;

    typedef struct {
        logic  sd;
        logic  fr;
        logic  bk;
        string sdtag;
        string frtag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n, edge_tick, bclk_inv, frame_inv, smp_valid;
    logic [2:0]    fmt_sel;
    logic [1:0]    width_sel;
    logic [SW-1:0] smp_left, smp_right;
    logic          smp_ready, bclk_o, frame_o, sdata_o, underrun_o;

    item_t q[$];
    int    checks = 0, errors = 0;
    int    ticks_sent = 0, tick_limit = 0, urun_cnt = 0;
    bit    tick_en = 0, sample_due = 0, done = 0;
    logic  prev_last = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    logic [31:0] cur_l = '0, cur_r = '0;

    int    f_fmt[NF], f_ws[NF];
    bit    f_bi[NF], f_fi[NF], f_give[NF];
    string f_sdt[NF], f_frt[NF];

    always #2.5 clk = ~clk;

    audio_serial_tx #(.SAMPLE_W(SW), .SLOT_BITS(SLOT)) u_audio_serial_tx (
        .clk(clk), .rst_n(rst_n), .edge_tick(edge_tick), .fmt_sel(fmt_sel),
        .width_sel(width_sel), .bclk_inv(bclk_inv), .frame_inv(frame_inv),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_left(smp_left),
        .smp_right(smp_right), .bclk_o(bclk_o), .frame_o(frame_o),
        .sdata_o(sdata_o), .underrun_o(underrun_o)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (ok !== 1'b1) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic int eff_w(input int ws);
        int w;
        case (ws)
            0: w = 16;
            1: w = 20;
            2: w = 24;
            default: w = 32;
        endcase
        if (w > SLOT) w = SLOT;
        return w;
    endfunction

    // Undelayed bit at position p, built from the requirement text.
    function automatic logic raw_b(input int fmt, input int w,
                                   input logic [31:0] l, input logic [31:0] r, input int p);
        int o;
        logic [31:0] wd;
        o  = (p >= SLOT) ? p - SLOT : p;
        wd = (p >= SLOT) ? r : l;
        if (fmt == 2) return (o >= SLOT - w) ? wd[SLOT - 1 - o] : 1'b0;
        if (fmt == 3 || fmt == 4) begin
            if (p < w)     return l[w - 1 - p];
            if (p < 2 * w) return r[2 * w - 1 - p];
            return 1'b0;
        end
        return (o < w) ? wd[w - 1 - o] : 1'b0;
    endfunction

    task automatic push_frame(input int f);
        int   fmt, w;
        logic last;
        item_t it;
        fmt  = (f_fmt[f] > 4) ? 1 : f_fmt[f];   // R13: codes 5-7 act as left-justified
        w    = eff_w(f_ws[f]);
        last = prev_last;
        for (int p = 0; p < FB; p++) begin
            if (fmt == 0 || fmt == 3) it.sd = (p == 0) ? last : raw_b(fmt, w, cur_l, cur_r, p - 1);
            else                      it.sd = raw_b(fmt, w, cur_l, cur_r, p);
            if (fmt == 3 || fmt == 4) it.fr = (p == 0);
            else                      it.fr = (p >= SLOT);
            it.fr    = it.fr ^ f_fi[f];
            it.bk    = !f_bi[f];
            it.sdtag = f_sdt[f];
            it.frtag = f_frt[f];
            q.push_back(it);
        end
        prev_last = raw_b(fmt, w, cur_l, cur_r, FB - 1);
    endtask

    task automatic set_cfg(input int f);
        fmt_sel   = 3'(f_fmt[f]);
        width_sel = 2'(f_ws[f]);
        bclk_inv  = f_bi[f];
        frame_inv = f_fi[f];
    endtask

    task automatic offer_pair();
        cur_l = next_rand();
        cur_r = next_rand();
        chk(smp_ready == 1'b1, "R11", "slot empty before offer", 32'(smp_ready), 32'd1);
        smp_left  = cur_l;
        smp_right = cur_r;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        chk(smp_ready == 1'b0, "R11", "slot full after handshake", 32'(smp_ready), 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Tick generator and monitor: pops expected bits at each rising bit clock.
    initial begin
        edge_tick = 1'b0;
        forever begin
            @(negedge clk);
            if (sample_due) begin
                item_t it;
                sample_due = 0;
                if (q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected bit position", 32'(sdata_o), 32'd0);
                end else begin
                    it = q.pop_front();
                    chk(sdata_o == it.sd, it.sdtag, "serial data bit", 32'(sdata_o), 32'(it.sd));
                    chk(frame_o == it.fr, it.frtag, "frame level", 32'(frame_o), 32'(it.fr));
                    chk(bclk_o == it.bk, "R2", "bit clock level at rise", 32'(bclk_o), 32'(it.bk));
                end
            end
            if (rst_n && underrun_o) urun_cnt++;
            if (edge_tick) begin
                edge_tick = 1'b0;
            end else if (tick_en && ticks_sent < tick_limit) begin
                edge_tick = 1'b1;
                if (ticks_sent % 2 == 0 && ticks_sent >= 2) sample_due = 1;
                ticks_sent++;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    // Driver: frame table, configuration and sample pairs.
    initial begin
        f_fmt = '{0, 0, 1, 2, 2, 4, 3, 3, 1, 0, 4, 6, 2};
        f_ws  = '{0, 3, 2, 1, 3, 0, 2, 3, 0, 0, 3, 1, 0};
        f_bi  = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0};
        f_fi  = '{0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0};
        f_give = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 1, 1};
        f_sdt = '{"R4", "R4", "R5", "R9", "R6", "R7", "R8", "R8", "R12", "R4", "R7", "R13", "R9"};
        f_frt = '{"R3", "R3", "R10", "R3", "R3", "R7", "R8", "R8", "R3", "R10", "R10", "R13", "R3"};

        rst_n = 1'b0; smp_valid = 1'b0; smp_left = '0; smp_right = '0;
        fmt_sel = '0; width_sel = '0; bclk_inv = 1'b0; frame_inv = 1'b0;
        tick_limit = 4 * SLOT * NF + 1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(bclk_o == 1'b0, "R1", "bclk after reset", 32'(bclk_o), 32'd0);
        chk(frame_o == 1'b0, "R1", "frame after reset", 32'(frame_o), 32'd0);
        chk(sdata_o == 1'b0, "R1", "data after reset", 32'(sdata_o), 32'd0);
        chk(smp_ready == 1'b1, "R1", "ready after reset", 32'(smp_ready), 32'd1);
        chk(underrun_o == 1'b0, "R1", "underrun after reset", 32'(underrun_o), 32'd0);

        set_cfg(0);
        offer_pair();
        push_frame(0);
        tick_en = 1;

        for (int f = 1; f < NF; f++) begin
            wait (ticks_sent >= 4 * SLOT * f - 2 * SLOT);
            @(negedge clk);
            set_cfg(f);                 // R13: set mid-frame, used from next frame
            if (f_give[f]) offer_pair();
            push_frame(f);
        end

        wait (ticks_sent >= tick_limit);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R3", "all bit positions sent", 32'(q.size()), 32'd0);
        chk(urun_cnt == 1, "R12", "underrun pulse count", 32'(urun_cnt), 32'd1);
        finish_run();
    end

endmodule